// File: doc/BRIEF.md
# Time-Sync Frame EtherType Classifier

This block watches an Ethernet frame pass a port one byte per beat on a stream interface. The first beat of a frame is the first byte of the destination address, and `s_last` marks the final byte. The block does not apply back-pressure: a beat is accepted whenever `s_valid` is high. From the accepted bytes it decides whether the frame is a time-synchronisation event. It first looks past zero, one or two VLAN tags, as the configuration selects. It then compares the encapsulated EtherType against two programmable type values, and each of those values has its own enable.

Frames that pass produce a one-cycle `evt_pulse`. With the pulse come a flag that names the matching type value and the number of tags the frame carried. All configuration arrives on plain input ports. The block samples it on the first beat of each frame and holds it until that frame ends.

Top module: `tsync_etype_classifier`

## Requirements
- R1: With both VLAN enables clear, the word formed from frame bytes 12 (high byte) and 13 (low byte) is the EtherType, and an event reports `evt_tags` = 0.
- R2: A frame is an event when its EtherType equals `cfg_type_a` while `cfg_type_a_en` is set (`evt_sel` = 0), or equals `cfg_type_b` while `cfg_type_b_en` is set (`evt_sel` = 1). When both match, `evt_sel` is 0. A type value whose enable is clear never matches.
- R3: With exactly one VLAN enable set, bytes 12–13 must equal the VLAN value that belongs to that enable (`cfg_vlan_a` for enable a, `cfg_vlan_b` for enable b). The EtherType is then at bytes 16–17, and an event reports `evt_tags` = 1.
- R4: With both VLAN enables set, the outer tag at bytes 12–13 must equal `cfg_vlan_a` and the inner tag at bytes 16–17 must equal `cfg_vlan_b`. The EtherType is then at bytes 20–21, and an event reports `evt_tags` = 2.
- R5: If an expected tag identifier differs from its configured value, the frame is not an event. The tag is never skipped in that case.
- R6: `evt_pulse` is high for exactly one cycle, in the cycle after the beat that carries the last EtherType byte. It rises at most once per frame.
- R7: A frame whose `s_last` beat comes before the last EtherType byte raises no event. The byte position restarts at 0 after every `s_last` beat.
- R8: Configuration is sampled on the first beat of a frame. Changes made later in the same frame have no effect on the decision for that frame.
- R9: Cycles with `s_valid` low do not advance the byte position.
- R10: After reset, `evt_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | A byte is present this cycle |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | This byte ends the frame |
| cfg_type_a | input | 16 | Type value a |
| cfg_type_b | input | 16 | Type value b |
| cfg_type_a_en | input | 1 | Enable for type value a |
| cfg_type_b_en | input | 1 | Enable for type value b |
| cfg_vlan_a | input | 16 | Tag identifier for the single tag under enable a, or the outer tag |
| cfg_vlan_b | input | 16 | Tag identifier for the single tag under enable b, or the inner tag |
| cfg_vlan_a_en | input | 1 | VLAN enable a |
| cfg_vlan_b_en | input | 1 | VLAN enable b |
| evt_pulse | output | 1 | One-cycle event indication |
| evt_sel | output | 1 | 0: type value a matched, 1: type value b matched |
| evt_tags | output | 2 | Number of tags skipped for this event (0, 1 or 2) |

## Verification
The bench sweeps every combination of VLAN enables and type enables against frames that carry zero, one or two tags, with tag identifiers that match or do not match and with three EtherTypes. This catches a design that skips a mismatching tag (a false event), that checks the inner tag against the wrong value (a missed or false event in stacked mode), or that gives type b priority when both values match (`evt_sel` is wrong). Frames cut short at every length around the EtherType position show whether the design fires from stale state. They also show an off-by-one in the firing beat, because the bench checks the exact beat after which the pulse appears. Idle gaps in the stream and configuration changes made in the middle of a frame expose a position counter that advances without a valid beat, and configuration that is not held for the whole frame.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TYPE_W = 16;

  typedef struct packed {
    logic [TYPE_W-1:0] type_a;
    logic [TYPE_W-1:0] type_b;
    logic [TYPE_W-1:0] vlan_a;
    logic [TYPE_W-1:0] vlan_b;
    logic              type_a_en;
    logic              type_b_en;
    logic              vlan_a_en;
    logic              vlan_b_en;
  } tsc_cfg_t;
endpackage

// File: rtl/tsc_beat_pos.sv
// Byte position inside the current frame; saturates, restarts after last.
module tsc_beat_pos #(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  output logic [POS_W-1:0] pos,
  output logic             first
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = beat;
    if (last)               pos_d = '0;
    else if (pos_q == POS_MAX) pos_d = pos_q;
    else                    pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos   = pos_q;
  assign first = (pos_q == '0);
endmodule

// File: rtl/tsc_cfg_hold.sv
// Captures configuration on the first beat of each frame.
module tsc_cfg_hold
  import tsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     first,
  input  tsc_cfg_t cfg_in,
  output tsc_cfg_t cfg_q
);
  logic cap_en;

  always_comb cap_en = beat && first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cap_en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/tsc_word_pack.sv
// Joins an even-position byte with the following odd-position byte.
module tsc_word_pack
  import tsc_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [7:0]        data,
  input  logic [POS_W-1:0]  pos,
  output logic              word_vld,
  output logic [TYPE_W-1:0] word,
  output logic [POS_W-1:0]  word_pos
);
  logic [7:0] hi_q;
  logic       hi_en;

  always_comb begin
    hi_en    = beat && !pos[0];
    word_vld = beat && pos[0];
    word     = {hi_q, data};
    word_pos = pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= data;
  end
endmodule

// File: rtl/tsc_decide.sv
// Tag checking, EtherType match and the registered event outputs.
module tsc_decide
  import tsc_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              last,
  input  logic              word_vld,
  input  logic [TYPE_W-1:0] word,
  input  logic [POS_W-1:0]  word_pos,
  input  tsc_cfg_t          cfg,
  output logic              evt_pulse,
  output logic              evt_sel,
  output logic [1:0]        evt_tags
);
  // low byte positions of the outer tag, the inner tag and the untagged type
  localparam logic [POS_W-1:0] OUTER_LO = POS_W'(13);
  localparam logic [POS_W-1:0] INNER_LO = POS_W'(17);
  localparam logic [POS_W-1:0] TYPE_LO  = POS_W'(13);

  logic [1:0]        n_tags;
  logic [POS_W-1:0]  type_lo;
  logic [TYPE_W-1:0] outer_exp;
  logic              outer_bad, inner_bad, at_type, hit_a, hit_b, fire;
  logic              fail_q, fail_d, done_q, done_d;
  logic              pulse_d, sel_d;
  logic [1:0]        tags_d;

  always_comb begin
    n_tags    = {1'b0, cfg.vlan_a_en} + {1'b0, cfg.vlan_b_en};
    type_lo   = TYPE_LO + POS_W'({n_tags, 2'b00});
    outer_exp = cfg.vlan_a_en ? cfg.vlan_a : cfg.vlan_b;
    outer_bad = word_vld && (n_tags != 2'd0) && (word_pos == OUTER_LO) &&
                (word != outer_exp);
    inner_bad = word_vld && (n_tags == 2'd2) && (word_pos == INNER_LO) &&
                (word != cfg.vlan_b);
    at_type   = word_vld && (word_pos == type_lo);
    hit_a     = cfg.type_a_en && (word == cfg.type_a);
    hit_b     = cfg.type_b_en && (word == cfg.type_b);
    fire      = at_type && !fail_q && !done_q && (hit_a || hit_b);
  end

  always_comb begin
    if (beat && last) begin
      fail_d = 1'b0;
      done_d = 1'b0;
    end else begin
      fail_d = fail_q || outer_bad || inner_bad;
      done_d = done_q || at_type;
    end
    pulse_d = fire;
    sel_d   = !hit_a;
    tags_d  = n_tags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q    <= 1'b0;
      done_q    <= 1'b0;
      evt_pulse <= 1'b0;
    end else begin
      fail_q    <= fail_d;
      done_q    <= done_d;
      evt_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_sel  <= 1'b0;
      evt_tags <= '0;
    end else if (fire) begin
      evt_sel  <= sel_d;
      evt_tags <= tags_d;
    end
  end
endmodule

// File: rtl/tsync_etype_classifier.sv
module tsync_etype_classifier
  import tsc_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic [TYPE_W-1:0] cfg_type_a,
  input  logic [TYPE_W-1:0] cfg_type_b,
  input  logic              cfg_type_a_en,
  input  logic              cfg_type_b_en,
  input  logic [TYPE_W-1:0] cfg_vlan_a,
  input  logic [TYPE_W-1:0] cfg_vlan_b,
  input  logic              cfg_vlan_a_en,
  input  logic              cfg_vlan_b_en,
  output logic              evt_pulse,
  output logic              evt_sel,
  output logic [1:0]        evt_tags
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [POS_W-1:0]  pos_q;
  logic              first;
  tsc_cfg_t          cfg_in, cfg_q;
  logic              word_vld;
  logic [TYPE_W-1:0] word;
  logic [POS_W-1:0]  word_pos;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    cfg_in.type_a    = cfg_type_a;
    cfg_in.type_b    = cfg_type_b;
    cfg_in.vlan_a    = cfg_vlan_a;
    cfg_in.vlan_b    = cfg_vlan_b;
    cfg_in.type_a_en = cfg_type_a_en;
    cfg_in.type_b_en = cfg_type_b_en;
    cfg_in.vlan_a_en = cfg_vlan_a_en;
    cfg_in.vlan_b_en = cfg_vlan_b_en;
  end

  tsc_beat_pos #(.POS_W(POS_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .beat  (s_valid),
    .last  (s_last),
    .pos   (pos_q),
    .first (first)
  );

  tsc_cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .beat   (s_valid),
    .first  (first),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  tsc_word_pack #(.POS_W(POS_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .beat     (s_valid),
    .data     (s_data),
    .pos      (pos_q),
    .word_vld (word_vld),
    .word     (word),
    .word_pos (word_pos)
  );

  tsc_decide #(.POS_W(POS_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .beat      (s_valid),
    .last      (s_last),
    .word_vld  (word_vld),
    .word      (word),
    .word_pos  (word_pos),
    .cfg       (cfg_q),
    .evt_pulse (evt_pulse),
    .evt_sel   (evt_sel),
    .evt_tags  (evt_tags)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
#(
  parameter int POS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic [POS_W-1:0] pos_q,
  input tsc_cfg_t         cfg_q,
  input logic             evt_pulse,
  input logic             evt_sel,
  input logic [1:0]       evt_tags
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse); // R6

  AST_PULSE_AFTER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(s_valid && (pos_q >= POS_W'(13)))); // R7

  AST_SEL_A_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && !evt_sel) |-> $past(cfg_q.type_a_en)); // R2

  AST_SEL_B_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && evt_sel) |-> $past(cfg_q.type_b_en)); // R2

  AST_TAGS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (evt_tags != 2'd3)); // R4

  AST_NO_TAG_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && $past(!cfg_q.vlan_a_en && !cfg_q.vlan_b_en)) |->
    (evt_tags == 2'd0)); // R1
endmodule

bind tsync_etype_classifier tsc_checker #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .pos_q     (pos_q),
  .cfg_q     (cfg_q),
  .evt_pulse (evt_pulse),
  .evt_sel   (evt_sel),
  .evt_tags  (evt_tags)
);

// File: tb/tb_tsync_etype_classifier.sv
`timescale 1ns/1ps
module tb_tsync_etype_classifier;
  localparam logic [15:0] TA = 16'h88F7, TB = 16'h88B5;
  localparam logic [15:0] VA = 16'h8100, VB = 16'h88A8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [15:0] c_ta, c_tb, c_va, c_vb;
  logic c_tae, c_tbe, c_vae, c_vbe;
  logic evt_pulse, evt_sel;
  logic [1:0] evt_tags;

  int total = 0, bad = 0;
  logic [7:0] frm [0:63];
  int n_pulse, p_at, p_sel, p_tags;
  logic swap_mid = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tsync_etype_classifier dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .cfg_type_a(c_ta), .cfg_type_b(c_tb), .cfg_type_a_en(c_tae), .cfg_type_b_en(c_tbe),
    .cfg_vlan_a(c_va), .cfg_vlan_b(c_vb), .cfg_vlan_a_en(c_vae), .cfg_vlan_b_en(c_vbe),
    .evt_pulse(evt_pulse), .evt_sel(evt_sel), .evt_tags(evt_tags));

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] wd(int p);
    return {frm[p], frm[p+1]};
  endfunction

  // build a frame carrying ft tags, tag ids t0/t1, EtherType et
  task automatic build(int ft, logic [15:0] t0, logic [15:0] t1, logic [15:0] et);
    for (int i = 0; i < 64; i++) frm[i] = 8'h10 + 8'(i);
    for (int k = 0; k < ft; k++) begin
      {frm[12+4*k], frm[13+4*k]} = (k == 0) ? t0 : t1;
      frm[14+4*k] = 8'h00;
      frm[15+4*k] = 8'h20 + 8'(k);
    end
    {frm[12+4*ft], frm[13+4*ft]} = et;
  endtask

  // expectation from the requirements and the bench's own frame bytes
  task automatic model(int len, output bit ev, output int at, output int sel, output int tg);
    bit ok = 1'b1;
    int n = int'(c_vae) + int'(c_vbe);
    logic [15:0] e;
    if (n >= 1 && len > 13 && wd(12) != (c_vae ? c_va : c_vb)) ok = 1'b0;  // R3 R5
    if (n == 2 && len > 17 && wd(16) != c_vb) ok = 1'b0;                   // R4 R5
    at = 13 + 4 * n;
    if (len <= at) ok = 1'b0;                                              // R7
    e = wd(12 + 4 * n);
    ev = 1'b0; sel = 0; tg = n;
    if (ok && c_tae && e == c_ta) ev = 1'b1;
    else if (ok && c_tbe && e == c_tb) begin ev = 1'b1; sel = 1; end
  endtask

  task automatic sample(int prev);
    if (evt_pulse === 1'b1) begin
      n_pulse++; p_at = prev; p_sel = int'(evt_sel); p_tags = int'(evt_tags);
    end
  endtask

  task automatic send(int len, bit gaps);
    int prev = -1;
    logic [15:0] sva = c_va, svb = c_vb, sta = c_ta;
    logic se = c_vae;
    n_pulse = 0; p_at = -1;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk); sample(prev); s_valid = 1'b0;
      end
      @(negedge clk); sample(prev);
      if (swap_mid && i == 1) begin
        c_va = 16'h1111; c_vb = 16'h2222; c_ta = 16'h3333; c_vae = ~c_vae;
      end
      s_valid = 1'b1; s_data = frm[i]; s_last = (i == len - 1); prev = i;
    end
    @(negedge clk); sample(prev); s_valid = 1'b0; s_last = 1'b0;
    @(negedge clk); sample(prev);
    @(negedge clk); sample(prev);
    if (swap_mid) begin c_va = sva; c_vb = svb; c_ta = sta; c_vae = se; end
  endtask

  task automatic check(string rq, int len);
    bit ev; int at, sel, tg;
    model(len, ev, at, sel, tg);
    total++;
    if (n_pulse != int'(ev) ||
        (ev && (p_at != at || p_sel != sel || p_tags != tg))) begin
      bad++;
      $display("FAIL %s: cfg v=%0d%0d t=%0d%0d len=%0d actual pulses=%0d at=%0d sel=%0d tags=%0d expected pulses=%0d at=%0d sel=%0d tags=%0d",
               rq, c_vae, c_vbe, c_tae, c_tbe, len, n_pulse, p_at, p_sel, p_tags,
               int'(ev), at, sel, tg);
    end
  endtask

  function automatic string req_of(int ft);
    int n = int'(c_vae) + int'(c_vbe);
    if (n != ft) return "R5";
    if (n == 0) return "R1 R2";
    if (n == 1) return "R3 R2";
    return "R4 R2";
  endfunction

  initial begin
    logic [15:0] tps [0:1];
    logic [15:0] ets [0:2];
    int fidx = 0;
    tps[0] = VA; tps[1] = VB;
    ets[0] = TA; ets[1] = TB; ets[2] = 16'h0800;
    c_ta = TA; c_tb = TB; c_va = VA; c_vb = VB;
    c_tae = 1'b0; c_tbe = 1'b0; c_vae = 1'b0; c_vbe = 1'b0;
    repeat (4) @(negedge clk);
    total++;  // R10
    if (evt_pulse !== 1'b0) begin
      bad++; $display("FAIL R10: actual pulse=%b expected 0", evt_pulse);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;  // R10
    if (evt_pulse !== 1'b0) begin
      bad++; $display("FAIL R10: actual pulse=%b after release expected 0", evt_pulse);
    end

    // full sweep: VLAN enables, type enables, tags present, tag ids, EtherType (R9 on odd frames)
    for (int v = 0; v < 4; v++)
      for (int t = 0; t < 4; t++)
        for (int ft = 0; ft < 3; ft++)
          for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
              for (int e = 0; e < 3; e++) begin
                c_vae = v[0]; c_vbe = v[1]; c_tae = t[0]; c_tbe = t[1];
                build(ft, tps[a], tps[b], ets[e]);
                send(40, fidx[0]);
                check(fidx[0] ? {req_of(ft), " R9 R6"} : {req_of(ft), " R6"}, 40);
                fidx++;
              end

    // R2: both type values equal, type a wins
    c_tb = TA; c_tae = 1'b1; c_tbe = 1'b1;
    for (int v = 0; v < 4; v++) begin
      c_vae = v[0]; c_vbe = v[1];
      build(int'(c_vae) + int'(c_vbe), VA, VB, TA);
      if (v == 2) {frm[12], frm[13]} = VB;
      send(40, 1'b0); check("R2 priority", 40);
    end
    c_tb = TB;

    // R7: truncated frames at every length around the type field, each followed by a full one
    for (int v = 0; v < 4; v++) begin
      c_vae = v[0]; c_vbe = v[1]; c_tae = 1'b1; c_tbe = 1'b1;
      for (int len = 1; len < 25; len++) begin
        build(int'(c_vae) + int'(c_vbe), c_vae ? VA : VB, VB, TB);
        send(len, 1'b0); check("R7 short", len);
        send(30, 1'b1); check("R7 restart", 30);
      end
    end

    // R8: configuration altered after the first beat must not matter
    swap_mid = 1'b1;
    for (int v = 0; v < 4; v++) begin
      c_vae = v[0]; c_vbe = v[1]; c_tae = 1'b1; c_tbe = 1'b0;
      build(int'(c_vae) + int'(c_vbe), c_vae ? VA : VB, VB, TA);
      send(40, 1'b0); check("R8 midframe", 40);
    end
    swap_mid = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule